// File: doc/BRIEF.md
# Framebuffer Scan-Out Controller

This block turns a small bank of 32-bit configuration words into raster timing for a display whose picture lives in memory. A host writes the visible size, the sync windows, the total line and frame lengths and a framebuffer base address through a word-indexed read/write port. The controller then walks a horizontal and a vertical counter and drives horizontal sync, vertical sync, a visible-area flag, the current pixel coordinates and the byte address of that pixel. A memory fetch engine downstream can use that address directly. Pixels are two bytes wide, so one line of the picture occupies twice the visible width in bytes.

Bit 0 of the control word parks the whole raster. While that bit is set, the counters sit at the origin and every video output is quiet. After reset the bit is set, so software programs the timing first and then clears the bit to start scanning. A base address takes effect only when the raster is at its origin, which lets software flip between two buffers without a visible tear. A separate read-only word reports the base that is actually in use.

Top module: `fbscan_ctrl`

## Requirements
- R1: After reset the words read back as follows: word 0 (control) = 1, word 1 (visible width) = 640, word 5 (visible height) = 480, and every other mapped word = 0.
- R2: The port is word-indexed. The words in index order are: 0 control, 1 visible width, 2 hsync on, 3 hsync off, 4 line total, 5 visible height, 6 vsync on, 7 vsync off, 8 frame total, 9 base address, 10 live base (read-only), 11 fetch length, 12 pixel-clock setting. Words 0–8, 11 and 12 store whatever is written, with no side effects. Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high.
- R3: Indices 13 and above are unmapped. Reads of them return 0, and writes to them change no word.
- R4: A write to word 9 whose bits [4:0] are not all zero is discarded. An aligned write stores the value ANDed with the `BASE_MASK` parameter.
- R5: Word 10 ignores writes and reads as the base address currently in use.
- R6: While control bit 0 is 1, the counters stay at 0 and `hsync`, `vsync`, `video_on`, `pix_x`, `pix_y` and `pix_addr` are all 0. After the bit is cleared, the first output sample is the origin (x = 0, y = 0), one cycle after the clearing write.
- R7: The horizontal count steps from 0 to the line total inclusive and then wraps to 0. The vertical count advances once per horizontal wrap and wraps to 0 after the frame total.
- R8: `hsync` is 1 exactly when `pix_x` is at least hsync-on and below hsync-off. `vsync` follows the same rule using `pix_y`, vsync-on and vsync-off.
- R9: `video_on` is 1 exactly when `pix_x` is below the visible width and `pix_y` is below the visible height.
- R10: `pix_addr` = B + `pix_y` × width × 2 + `pix_x` × 2, where B is the live base for that frame.
- R11: The live base takes the programmed base only while both counters are at 0. This includes the parked state. A base written mid-frame first shows up at the next origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | REG_IX_W (4) | Word index of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, registered |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| video_on | output | 1 | Pixel is inside the visible area |
| pix_x | output | CNT_W (12) | Current column |
| pix_y | output | CNT_W (12) | Current row |
| pix_addr | output | DATA_W (32) | Byte address of the current pixel |

## Verification
The bench uses a tiny raster of 11 columns by 8 lines so that it can compare every cycle of two full frames against its own counter model. In those frames it checks both sync windows, the visible flag and the pixel address. A base address is written in the middle of the first frame. A controller that latched the base immediately would shear the picture in the middle of a line, and the address check catches that before the second origin. Misaligned and masked base writes, writes to the read-only live word and writes to unmapped indices are each followed by a full read-back of the map, so a write that leaked into a neighbouring word shows up. Parking the raster mid-frame and releasing it must restart at the origin, so a design that resumed from where it stopped, or that let sync leak out while parked, fails that check.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  // Word indices of the configuration bank; the order is the software map.
  localparam int IX_CTL       = 0;
  localparam int IX_H_ACT     = 1;
  localparam int IX_HS_ON     = 2;
  localparam int IX_HS_OFF    = 3;
  localparam int IX_H_TOT     = 4;
  localparam int IX_V_ACT     = 5;
  localparam int IX_VS_ON     = 6;
  localparam int IX_VS_OFF    = 7;
  localparam int IX_V_TOT     = 8;
  localparam int IX_BASE      = 9;
  localparam int IX_BASE_LIVE = 10;
  localparam int IX_FETCH     = 11;
  localparam int IX_PCLK      = 12;
  localparam int NUM_REGS     = 13;

  // Axis selector used by the sync/visible window generator.
  typedef enum logic {AX_H = 1'b0, AX_V = 1'b1} axis_e;
endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs
  import fbscan_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          REG_IX_W   = 4,
  parameter int          CNT_W      = 12,
  parameter int          ALIGN_BITS = 5,
  parameter logic [31:0] BASE_MASK  = 32'hFFFF_FFFF,
  parameter int          H_DEF      = 640,
  parameter int          V_DEF      = 480
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_IX_W-1:0] idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   live_base,
  output logic [DATA_W-1:0]   rdata,
  output logic                hold,
  output logic [CNT_W-1:0]    h_act,
  output logic [CNT_W-1:0]    hs_on,
  output logic [CNT_W-1:0]    hs_off,
  output logic [CNT_W-1:0]    h_tot,
  output logic [CNT_W-1:0]    v_act,
  output logic [CNT_W-1:0]    vs_on,
  output logic [CNT_W-1:0]    vs_off,
  output logic [CNT_W-1:0]    v_tot,
  output logic [DATA_W-1:0]   base_cfg
);
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(BASE_MASK);

  logic [DATA_W-1:0] store [NUM_REGS];
  logic              idx_ok;
  logic              aligned;
  logic [DATA_W-1:0] rd_word;

  assign idx_ok  = (int'(idx) < NUM_REGS);
  assign aligned = (wdata[ALIGN_BITS-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) store[i] <= '0;
      store[IX_CTL]   <= DATA_W'(1);
      store[IX_H_ACT] <= DATA_W'(H_DEF);
      store[IX_V_ACT] <= DATA_W'(V_DEF);
    end else if (wr_en && idx_ok) begin
      case (int'(idx))
        IX_BASE:      if (aligned) store[IX_BASE] <= wdata & MASK_W;
        IX_BASE_LIVE: ;
        default:      store[idx] <= wdata;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    if (idx_ok) rd_word = store[idx];
    if (int'(idx) == IX_BASE_LIVE) rd_word = live_base;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign hold     = store[IX_CTL][0];
  assign h_act    = store[IX_H_ACT][CNT_W-1:0];
  assign hs_on    = store[IX_HS_ON][CNT_W-1:0];
  assign hs_off   = store[IX_HS_OFF][CNT_W-1:0];
  assign h_tot    = store[IX_H_TOT][CNT_W-1:0];
  assign v_act    = store[IX_V_ACT][CNT_W-1:0];
  assign vs_on    = store[IX_VS_ON][CNT_W-1:0];
  assign vs_off   = store[IX_VS_OFF][CNT_W-1:0];
  assign v_tot    = store[IX_V_TOT][CNT_W-1:0];
  assign base_cfg = store[IX_BASE];
endmodule

// File: rtl/fbscan_timing.sv
module fbscan_timing #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [CNT_W-1:0] h_tot,
  input  logic [CNT_W-1:0] v_tot,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] vcnt,
  output logic             at_origin
);
  logic line_end;
  logic frame_end;

  // >= rather than == so a total lowered below the count still wraps.
  assign line_end  = (hcnt >= h_tot);
  assign frame_end = (vcnt >= v_tot);
  assign at_origin = (hcnt == '0) && (vcnt == '0);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbscan_pixout.sv
module fbscan_pixout
  import fbscan_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 12,
  parameter int BPP_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [CNT_W-1:0]  hcnt,
  input  logic [CNT_W-1:0]  vcnt,
  input  logic              at_origin,
  input  logic [CNT_W-1:0]  h_act,
  input  logic [CNT_W-1:0]  hs_on,
  input  logic [CNT_W-1:0]  hs_off,
  input  logic [CNT_W-1:0]  v_act,
  input  logic [CNT_W-1:0]  vs_on,
  input  logic [CNT_W-1:0]  vs_off,
  input  logic [DATA_W-1:0] base_cfg,
  output logic [DATA_W-1:0] live_base,
  output logic              hsync,
  output logic              vsync,
  output logic              video_on,
  output logic [CNT_W-1:0]  pix_x,
  output logic [CNT_W-1:0]  pix_y,
  output logic [DATA_W-1:0] pix_addr
);
  localparam logic [DATA_W-1:0] PIX_BYTES = DATA_W'(BPP_BYTES);

  logic [CNT_W-1:0] ax_cnt [2];
  logic [CNT_W-1:0] ax_on  [2];
  logic [CNT_W-1:0] ax_off [2];
  logic [CNT_W-1:0] ax_act [2];
  logic [1:0]       in_sync;
  logic [1:0]       in_act;

  assign ax_cnt[AX_H] = hcnt;   assign ax_cnt[AX_V] = vcnt;
  assign ax_on[AX_H]  = hs_on;  assign ax_on[AX_V]  = vs_on;
  assign ax_off[AX_H] = hs_off; assign ax_off[AX_V] = vs_off;
  assign ax_act[AX_H] = h_act;  assign ax_act[AX_V] = v_act;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    assign in_sync[a] = (ax_cnt[a] >= ax_on[a]) && (ax_cnt[a] < ax_off[a]);
    assign in_act[a]  = (ax_cnt[a] < ax_act[a]);
  end

  // At the origin the freshly programmed base applies to this very pixel.
  logic [DATA_W-1:0] base_eff;
  logic [DATA_W-1:0] line_off;
  logic [DATA_W-1:0] col_off;
  logic [DATA_W-1:0] addr_next;

  assign base_eff  = at_origin ? base_cfg : live_base;
  assign line_off  = DATA_W'(vcnt) * DATA_W'(h_act) * PIX_BYTES;
  assign col_off   = DATA_W'(hcnt) * PIX_BYTES;
  assign addr_next = base_eff + line_off + col_off;

  always_ff @(posedge clk) begin
    if (rst)            live_base <= '0;
    else if (at_origin) live_base <= base_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      video_on <= 1'b0;
      pix_x    <= '0;
      pix_y    <= '0;
      pix_addr <= '0;
    end else begin
      hsync    <= in_sync[AX_H];
      vsync    <= in_sync[AX_V];
      video_on <= &in_act;
      pix_x    <= hcnt;
      pix_y    <= vcnt;
      pix_addr <= addr_next;
    end
  end
endmodule

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl #(
  parameter int          DATA_W     = 32,
  parameter int          REG_IX_W   = 4,
  parameter int          CNT_W      = 12,
  parameter int          ALIGN_BITS = 5,
  parameter int          BPP_BYTES  = 2,
  parameter logic [31:0] BASE_MASK  = 32'hFFFF_FFFF,
  parameter int          H_DEF      = 640,
  parameter int          V_DEF      = 480
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_IX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                hsync,
  output logic                vsync,
  output logic                video_on,
  output logic [CNT_W-1:0]    pix_x,
  output logic [CNT_W-1:0]    pix_y,
  output logic [DATA_W-1:0]   pix_addr
);
  logic              hold;
  logic [CNT_W-1:0]  h_act, hs_on, hs_off, h_tot;
  logic [CNT_W-1:0]  v_act, vs_on, vs_off, v_tot;
  logic [DATA_W-1:0] base_cfg;
  logic [DATA_W-1:0] live_base;
  logic [CNT_W-1:0]  hcnt, vcnt;
  logic              at_origin;

  fbscan_regs #(
    .DATA_W(DATA_W), .REG_IX_W(REG_IX_W), .CNT_W(CNT_W),
    .ALIGN_BITS(ALIGN_BITS), .BASE_MASK(BASE_MASK),
    .H_DEF(H_DEF), .V_DEF(V_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .idx(reg_idx),
    .wdata(reg_wdata), .live_base(live_base), .rdata(reg_rdata),
    .hold(hold), .h_act(h_act), .hs_on(hs_on), .hs_off(hs_off),
    .h_tot(h_tot), .v_act(v_act), .vs_on(vs_on), .vs_off(vs_off),
    .v_tot(v_tot), .base_cfg(base_cfg)
  );

  fbscan_timing #(.CNT_W(CNT_W)) u_timing (
    .clk(clk), .rst(rst), .hold(hold), .h_tot(h_tot), .v_tot(v_tot),
    .hcnt(hcnt), .vcnt(vcnt), .at_origin(at_origin)
  );

  fbscan_pixout #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .BPP_BYTES(BPP_BYTES)
  ) u_pix (
    .clk(clk), .rst(rst), .hold(hold), .hcnt(hcnt), .vcnt(vcnt),
    .at_origin(at_origin), .h_act(h_act), .hs_on(hs_on), .hs_off(hs_off),
    .v_act(v_act), .vs_on(vs_on), .vs_off(vs_off), .base_cfg(base_cfg),
    .live_base(live_base), .hsync(hsync), .vsync(vsync),
    .video_on(video_on), .pix_x(pix_x), .pix_y(pix_y), .pix_addr(pix_addr)
  );
endmodule

// File: rtl/fbscan_chk.sv
module fbscan_chk
  import fbscan_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_IX_W   = 4,
  parameter int CNT_W      = 12,
  parameter int ALIGN_BITS = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hold,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [REG_IX_W-1:0]   reg_idx,
  input logic [ALIGN_BITS-1:0] wr_low,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic [CNT_W-1:0]      hcnt,
  input logic [CNT_W-1:0]      vcnt,
  input logic [CNT_W-1:0]      h_tot,
  input logic [CNT_W-1:0]      hs_on,
  input logic [CNT_W-1:0]      hs_off,
  input logic [CNT_W-1:0]      h_act,
  input logic [CNT_W-1:0]      v_act,
  input logic [DATA_W-1:0]     base_cfg,
  input logic [DATA_W-1:0]     live_base,
  input logic                  hsync,
  input logic                  vsync,
  input logic                  video_on,
  input logic [CNT_W-1:0]      pix_x,
  input logic [CNT_W-1:0]      pix_y,
  input logic [DATA_W-1:0]     pix_addr
);
  // R3: unmapped reads return zero
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && int'(reg_idx) >= NUM_REGS) |=> (reg_rdata == '0));

  // R4: a misaligned base write leaves the programmed base untouched
  a_r4_misaligned_drop: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(reg_idx) == IX_BASE && wr_low != '0) |=> $stable(base_cfg));

  // R6: parked raster keeps every video output quiet
  a_r6_parked_quiet: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!hsync && !vsync && !video_on && pix_x == '0 && pix_y == '0
              && pix_addr == '0));

  // R7: horizontal count steps by one below the total
  a_r7_h_step: assert property (@(posedge clk) disable iff (rst)
    (!hold && hcnt < h_tot) |=> (hcnt == $past(hcnt) + 1'b1));

  // R7: horizontal count wraps at the total
  a_r7_h_wrap: assert property (@(posedge clk) disable iff (rst)
    (!hold && hcnt >= h_tot) |=> (hcnt == '0));

  // R8: hsync window follows the reported column
  a_r8_hsync_window: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (hsync == (pix_x >= $past(hs_on) && pix_x < $past(hs_off))));

  // R9: visible flag follows the reported position
  a_r9_visible: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (video_on == (pix_x < $past(h_act) && pix_y < $past(v_act))));

  // R11: live base only moves at the origin
  a_r11_base_steady: assert property (@(posedge clk) disable iff (rst)
    (hcnt != '0 || vcnt != '0) |=> $stable(live_base));
endmodule

bind fbscan_ctrl fbscan_chk #(
  .DATA_W(DATA_W), .REG_IX_W(REG_IX_W), .CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_idx(reg_idx), .wr_low(reg_wdata[ALIGN_BITS-1:0]),
  .reg_rdata(reg_rdata), .hcnt(hcnt), .vcnt(vcnt), .h_tot(h_tot),
  .hs_on(hs_on), .hs_off(hs_off), .h_act(h_act), .v_act(v_act),
  .base_cfg(base_cfg), .live_base(live_base), .hsync(hsync), .vsync(vsync),
  .video_on(video_on), .pix_x(pix_x), .pix_y(pix_y), .pix_addr(pix_addr)
);

// File: tb/sim_fbscan_ctrl.sv
module sim_fbscan_ctrl;
  localparam int          DW   = 32;
  localparam int          IW   = 4;
  localparam int          CW   = 12;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;

  // small raster used by the scan tests
  localparam int HA = 6, HON = 7, HOFF = 9, HT = 10;
  localparam int VA = 4, VON = 5, VOFF = 6, VT = 7;
  localparam int FRAME = (HT + 1) * (VT + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [IW-1:0] reg_idx = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          hsync, vsync, video_on;
  logic [CW-1:0] pix_x, pix_y;
  logic [DW-1:0] pix_addr;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [31:0] shadow [16];

  always #4 clk = ~clk;

  fbscan_ctrl #(.BASE_MASK(MASK)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync(hsync), .vsync(vsync), .video_on(video_on),
    .pix_x(pix_x), .pix_y(pix_y), .pix_addr(pix_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = IW'(ix); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = IW'(ix);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic check_map(input string req);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk(req, v, shadow[i]);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    shadow[0] = 32'd1; shadow[1] = 32'd640; shadow[5] = 32'd480;
    check_map("R1 reset map");
    chk("R6 parked video_on", {31'd0, video_on}, 32'd0);
  endtask

  task automatic t_plain_rw;
    int ids [8] = '{2, 3, 4, 6, 7, 8, 11, 12};
    foreach (ids[k]) begin
      shadow[ids[k]] = 32'hA5C3_0000 ^ (32'(ids[k]) * 32'h0101_1111);
      wr(ids[k], shadow[ids[k]]);
    end
    check_map("R2 plain read-back");
    wr(13, 32'hDEAD_BEEF);
    wr(15, 32'h1234_5678);
    check_map("R3 unmapped write/read");
  endtask

  task automatic t_base;
    wr(9, 32'h1000_0020);
    shadow[9] = 32'h1000_0020 & MASK; shadow[10] = shadow[9];
    check_map("R4 aligned base masked");
    wr(9, 32'h0000_0471);
    check_map("R4 misaligned base dropped");
    wr(10, 32'hFFFF_FFE0);
    check_map("R5 live base write ignored");
  endtask

  task automatic t_scan;
    int ex = 0, ey = 0;
    logic [31:0] bcur, bnext;
    shadow[1] = HA; shadow[2] = HON; shadow[3] = HOFF; shadow[4] = HT;
    shadow[5] = VA; shadow[6] = VON; shadow[7] = VOFF; shadow[8] = VT;
    for (int i = 1; i <= 8; i++) wr(i, shadow[i]);
    wr(9, 32'h0000_0100);
    bcur = 32'h100; bnext = bcur;
    // R6: register update edge still shows the parked state
    wr(0, 32'd0);
    chk("R6 quiet on clearing cycle", {31'd0, video_on}, 32'd0);
    for (int n = 0; n < 2 * FRAME + 5; n++) begin
      @(negedge clk);
      if (reg_wr) reg_wr = 1'b0;
      chk("R7 column", 32'(pix_x), 32'(ex));
      chk("R7 row", 32'(pix_y), 32'(ey));
      chk("R8 hsync", {31'd0, hsync}, {31'd0, (ex >= HON && ex < HOFF)});
      chk("R8 vsync", {31'd0, vsync}, {31'd0, (ey >= VON && ey < VOFF)});
      chk("R9 visible", {31'd0, video_on}, {31'd0, (ex < HA && ey < VA)});
      chk("R10/R11 address", pix_addr, bcur + 32'(ey * HA * 2 + ex * 2));
      if (n < FRAME && ex == 3 && ey == 2) begin
        reg_wr = 1'b1; reg_idx = IW'(9); reg_wdata = 32'h0000_2000;
        bnext = 32'h2000;
      end
      ex++;
      if (ex > HT) begin
        ex = 0; ey++;
        if (ey > VT) ey = 0;
      end
      if (ex == 0 && ey == 0) bcur = bnext;
    end
    shadow[9] = 32'h2000; shadow[10] = 32'h2000;
    begin
      logic [31:0] v;
      rd(10, v);
      chk("R5 live base in use", v, 32'h2000);
    end
  endtask

  task automatic t_repark;
    wr(0, 32'd1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R6 parked outputs",
          {hsync, vsync, video_on, 5'd0, 12'(pix_x), 12'(pix_y)} | pix_addr, 32'd0);
    end
    wr(0, 32'd0);
    @(negedge clk);
    chk("R6 restart column", 32'(pix_x), 32'd0);
    chk("R6 restart row", 32'(pix_y), 32'd0);
    chk("R6 restart visible", {31'd0, video_on}, 32'd1);
    chk("R10 restart address", pix_addr, 32'h2000);
    @(negedge clk);
    chk("R7 first step", 32'(pix_x), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain_rw();
    t_base();
    t_scan();
    t_repark();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule